// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter, clocked through a free-running prescaler, that serves either as a periodic interval timer or as a watchdog. In interval mode each counter wrap sets an overflow flag, and the interrupt request stays raised until software clears that flag. In watchdog mode a wrap asks for a system reset, provided the reset-enable input is high. Software must keep rewriting the control register so that the counter never wraps.

The prescaler offers eight divide taps, from /2 to /131072 of the system clock, and a 3-bit select field picks one of them. A full period is 256 ticks of the chosen tap. The control register can only be written through a 16-bit access whose upper byte carries a fixed key. Reads are plain byte reads. Clearing the flag takes two steps: a read must first see the flag set, and then a keyed write stores 0 in the flag bit.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the counter reads 0x00, irq and rst_req are 0, and the register reads 0x18: flag 0, mode 0, enable 0, reserved bits 1, select 000.
- R2: While the enable bit (register bit 5) is 0, the counter is cleared to 0x00 and stays there. While it is 1, the counter adds one on each tick of the selected tap.
- R3: The select field (bits 2..0) chooses the tap. The codes 0 to 7 divide the clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. The prescaler runs freely, and a tap ticks on the clock in which the low log2(divisor) prescaler bits are all ones.
- R4: When a tick moves the counter from 0xFF to 0x00, the overflow flag (bit 7) is set on that same edge.
- R5: The flag is cleared only by a keyed write with bit 7 = 0, and only when an earlier read saw the flag at 1. Any keyed write uses up that read. A keyed write with bit 7 = 1, or without the earlier read, leaves the flag unchanged. On the same edge, an overflow takes priority over a clear.
- R6: irq is 1 exactly when the flag is 1 and the mode bit (bit 6) is 0, which selects interval mode.
- R7: In watchdog mode (bit 6 = 1), an overflow while rst_enable is 1 drives rst_req high for PULSE_LEN (default 16) clocks, starting on the clock after the overflow. When rst_enable is 0, no pulse is produced.
- R8: The flag set by an overflow that raised a reset pulse clears on its own, in the cycle in which rst_req falls.
- R9: Bits 4..3 always read as 1, and writes to them have no effect.
- R10: A write changes the register only when bus_wide is 1 and bus_wdata[15:8] equals 0xA5. In that case bus_wdata[7:0] is the new value. Any other write leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit write access |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rdata | output | 8 | Control/status register value |
| rst_enable | input | 1 | Permits reset requests in watchdog mode |
| irq | output | 1 | Interval-timer interrupt request |
| rst_req | output | 1 | Reset request pulse |
| count_out | output | 8 | Current counter value |

## Verification
The counter is run on every tap that fits within the run: taps /2 through /32768 for two periods each, and /131072 over a shorter window. This shows that each select code picks its own divisor and not a neighbouring one. Several flag sequences are tried: a clear without a prior read, a keyed write of 1 after a read, and a proper read-then-write-0. These tell the two-step handshake apart from a plain write-to-clear. Writes with a wrong key, and byte-wide writes with the right key, show that only the full keyed access reaches the register. Watchdog overflows with rst_enable high and low separate the reset pulse and its automatic flag clear from the interval interrupt path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int NUM_TAPS  = 8;
   localparam int SEL_W     = 3;
   localparam int MAX_LOG2  = 17;

   // log2 of the divisor selected by each select code
   function automatic int tap_log2(input int code);
      case (code)
         0:       return 1;
         1:       return 6;
         2:       return 7;
         3:       return 9;
         4:       return 11;
         5:       return 13;
         6:       return 15;
         default: return 17;
      endcase
   endfunction

   typedef struct packed {
      logic             mode;
      logic             en;
      logic [SEL_W-1:0] sel;
   } wdt_ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRE_W  = wdt_pkg::MAX_LOG2,
   parameter int NTAPS  = wdt_pkg::NUM_TAPS
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [NTAPS-1:0] taps
);
   logic [PRE_W-1:0] pre_q;

   generate
      if (PRE_W < wdt_pkg::MAX_LOG2) begin : g_bad_width
         $error("prescaler narrower than the widest tap");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar t = 0; t < NTAPS; t++) begin : g_tap
      localparam int LG = wdt_pkg::tap_log2(t);
      assign taps[t] = &pre_q[LG-1:0];
   end
endmodule

// File: rtl/wdt_count_unit.sv
module wdt_count_unit #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("counter too narrow");
      end
   endgenerate

   assign wrap = en && tick && (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (!en)   count <= '0;
      else if (tick)  count <= count + 1'b1;
   end
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_stb,
   input  logic       key_wr,
   input  logic [7:0] wval,
   input  logic       ovf,
   input  logic       auto_clr,
   output logic       flag,
   output wdt_ctrl_t  ctrl
);
   logic armed_q;
   logic unused_rsv;

   assign unused_rsv = ^wval[4:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         armed_q <= 1'b0;
         ctrl    <= '0;
      end else begin
         if (ovf)
            flag <= 1'b1;
         else if (auto_clr)
            flag <= 1'b0;
         else if (key_wr && !wval[7] && armed_q)
            flag <= 1'b0;

         if (rd_stb && flag)
            armed_q <= 1'b1;
         else if (key_wr)
            armed_q <= 1'b0;

         if (key_wr) begin
            ctrl.mode <= wval[6];
            ctrl.en   <= wval[5];
            ctrl.sel  <= wval[SEL_W-1:0];
         end
      end
   end
endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse #(
   parameter int PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req,
   output logic ending
);
   localparam int PW = $clog2(PULSE_LEN + 1);
   localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

   logic [PW-1:0] left_q;

   generate
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("pulse length must be at least one clock");
      end
   endgenerate

   assign req    = (left_q != '0);
   assign ending = (left_q == PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left_q <= '0;
      else if (fire)   left_q <= LEN;
      else if (req)    left_q <= left_q - 1'b1;
   end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int         CNT_W     = 8,
   parameter int         PULSE_LEN = 16,
   parameter logic [7:0] KEY       = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic        bus_wide,
   input  logic [15:0] bus_wdata,
   output logic [7:0]  bus_rdata,
   input  logic        rst_enable,
   output logic        irq,
   output logic        rst_req,
   output logic [7:0]  count_out
);
   logic [NUM_TAPS-1:0] taps;
   logic                tap_tick;
   logic                wrap;
   logic                flag;
   logic                auto_clr;
   logic                key_wr;
   logic                rd_stb;
   logic [CNT_W-1:0]    count;
   wdt_ctrl_t           ctrl;

   generate
      if (CNT_W != 8) begin : g_bad_port
         $error("count_out is fixed at 8 bits");
      end
   endgenerate

   assign key_wr = bus_sel && bus_wr && bus_wide && (bus_wdata[15:8] == KEY);
   assign rd_stb = bus_sel && !bus_wr;

   wdt_prescaler #(.PRE_W(MAX_LOG2), .NTAPS(NUM_TAPS)) u_pre (
      .clk(clk), .rst_n(rst_n), .taps(taps)
   );

   assign tap_tick = taps[ctrl.sel];

   wdt_count_unit #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(ctrl.en), .tick(tap_tick),
      .count(count), .wrap(wrap)
   );

   wdt_ctrl_regs u_regs (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .key_wr(key_wr),
      .wval(bus_wdata[7:0]), .ovf(wrap), .auto_clr(auto_clr),
      .flag(flag), .ctrl(ctrl)
   );

   wdt_reset_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(wrap && ctrl.mode && rst_enable),
      .req(rst_req), .ending(auto_clr)
   );

   assign irq       = flag && !ctrl.mode;
   assign count_out = count;
   assign bus_rdata = {flag, ctrl.mode, ctrl.en, 2'b11, ctrl.sel};
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int PULSE_LEN = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_wr,
   input logic        bus_wide,
   input logic [15:0] bus_wdata,
   input logic [7:0]  bus_rdata,
   input logic        irq,
   input logic        rst_req,
   input logic [7:0]  count_out,
   input logic        tap_tick
);
   int hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_run <= 0;
      else if (rst_req) hi_run <= hi_run + 1;
      else              hi_run <= 0;
   end

   assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[4:3] == 2'b11);

   assert_irq_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (bus_rdata[7] && !bus_rdata[6]));

   assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rdata[5] |=> count_out == 8'h00);

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[5] && !tap_tick) |=> (count_out == $past(count_out)) || (count_out == 8'h00));

   assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[5] && tap_tick && count_out == 8'hFF) |=> bus_rdata[7]);

   assert_pulse_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(bus_rdata[6]));

   assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run <= PULSE_LEN);

   assert_keyless_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && (!bus_wide || bus_wdata[15:8] != 8'hA5))
      |=> ({bus_rdata[6:5], bus_rdata[2:0]} == $past({bus_rdata[6:5], bus_rdata[2:0]})));
endmodule

bind wdt_timer wdt_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq(irq), .rst_req(rst_req), .count_out(count_out), .tap_tick(tap_tick)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
   localparam int CLK_PERIOD = 10;
   localparam int PLEN       = 16;
   localparam int LIMIT      = 190000;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_sel = 0, bus_wr = 0, bus_wide = 0, rst_enable = 0;
   logic [15:0] bus_wdata = 0;
   logic [7:0]  bus_rdata, count_out;
   logic        irq, rst_req;

   int errors = 0, checks = 0, cycles = 0;
   bit done = 0;

   // behavioural model state
   int m_pre, m_cnt, m_pcnt;
   bit m_flag, m_mode, m_en, m_arm;
   int m_sel;

   wdt_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_enable(rst_enable), .irq(irq), .rst_req(rst_req), .count_out(count_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int divisor(input int code);
      int lg [8] = '{1, 6, 7, 9, 11, 13, 15, 17};
      return 1 << lg[code];
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_pcnt = 0; m_flag = 0; m_mode = 0;
         m_en = 0; m_arm = 0; m_sel = 0;
      end else begin
         int d; bit tick, ovf, key, rd, wdclr;
         int n_cnt, n_pcnt; bit n_flag, n_arm;
         cycles++;
         d = divisor(m_sel);
         tick = m_en && ((m_pre % d) == d - 1);
         ovf = tick && (m_cnt == 255);
         key = bus_sel && bus_wr && bus_wide && (bus_wdata[15:8] == 8'hA5);
         rd = bus_sel && !bus_wr;
         wdclr = (m_pcnt == 1);
         n_cnt = !m_en ? 0 : (tick ? (m_cnt + 1) % 256 : m_cnt);
         if (ovf) n_flag = 1;
         else if (wdclr) n_flag = 0;
         else if (key && !bus_wdata[7] && m_arm) n_flag = 0;
         else n_flag = m_flag;
         if (rd && m_flag) n_arm = 1;
         else if (key) n_arm = 0;
         else n_arm = m_arm;
         if (ovf && m_mode && rst_enable) n_pcnt = PLEN;
         else if (m_pcnt > 0) n_pcnt = m_pcnt - 1;
         else n_pcnt = 0;
         if (key) begin
            m_mode = bus_wdata[6]; m_en = bus_wdata[5]; m_sel = int'(bus_wdata[2:0]);
         end
         m_cnt = n_cnt; m_flag = n_flag; m_arm = n_arm; m_pcnt = n_pcnt;
         m_pre = (m_pre + 1) % 131072;
      end
   end

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 count", int'(count_out), m_cnt);
         check("R6 irq", int'(irq), int'(m_flag && !m_mode));
         check("R7 rst_req", int'(rst_req), int'(m_pcnt != 0));
         check("R9 register", int'(bus_rdata),
               (int'(m_flag) << 7) | (int'(m_mode) << 6) | (int'(m_en) << 5) | 8'h18 | m_sel);
      end
   end

   initial begin : watchdog
      int n = 0;
      while (!done && n < LIMIT) begin @(posedge clk); n++; end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired after %0d cycles", n);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] v, input logic wide);
      bus_sel = 1; bus_wr = 1; bus_wide = wide; bus_wdata = v;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; bus_wide = 0; bus_wdata = 0;
   endtask

   task automatic rd(output logic [7:0] v);
      bus_sel = 1; bus_wr = 0;
      v = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic wait_flag();
      int n = 0;
      while (!m_flag && n < 2000) begin @(negedge clk); n++; end
   endtask

   initial begin
      logic [7:0] v;
      int hi;
      @(negedge clk); @(negedge clk);
      // R1 reset state
      check("R1 rdata", int'(bus_rdata), 8'h18);
      check("R1 count", int'(count_out), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 rst_req", int'(rst_req), 0);
      rst_n = 1;
      idle(3);

      // R10 wrong key and byte-wide writes are ignored
      wr(16'h5A25, 1);
      check("R10 bad key", int'(bus_rdata), 8'h18);
      wr(16'hA525, 0);
      check("R10 narrow write", int'(bus_rdata), 8'h18);
      // R9 reserved bits ignore a written 0
      wr(16'hA520, 1);
      check("R9 reserved read", int'(bus_rdata[4:3]), 3);
      check("R10 keyed write", int'(bus_rdata), 8'h38);

      // R3 each tap for two of its periods (the model compares every clock)
      for (int c = 0; c < 7; c++) begin
         wr(16'hA500, 1);
         idle(2);
         check("R2 disabled", int'(count_out), 0);
         wr(16'hA520 | 16'(c), 1);
         idle(2 * divisor(c));
         check("R3 tap count", int'(count_out), m_cnt);
         check("R3 tap advanced", int'(count_out >= 1), 1);
      end
      wr(16'hA527, 1);
      idle(20000);
      check("R3 slowest tap", int'(count_out), m_cnt);

      // R4/R5/R6 interval overflow and flag handshake
      wr(16'hA500, 1);
      wr(16'hA520, 1);
      wait_flag();
      check("R4 flag set", int'(bus_rdata[7]), 1);
      check("R6 irq high", int'(irq), 1);
      wr(16'hA520, 1);
      check("R5 clear without read", int'(bus_rdata[7]), 1);
      rd(v);
      check("R5 read sees flag", int'(v[7]), 1);
      wr(16'hA5A0, 1);
      check("R5 write one", int'(bus_rdata[7]), 1);
      wr(16'hA520, 1);
      check("R5 arm used up", int'(bus_rdata[7]), 1);
      rd(v);
      wr(16'hA520, 1);
      check("R5 proper clear", int'(bus_rdata[7]), 0);
      check("R6 irq low", int'(irq), 0);

      // R7 watchdog with rst_enable low: flag, no pulse, no irq
      rst_enable = 0;
      wr(16'hA500, 1);
      wr(16'hA560, 1);
      wait_flag();
      idle(2);
      check("R7 no pulse", int'(rst_req), 0);
      check("R6 no irq in watchdog", int'(irq), 0);
      rd(v);
      wr(16'hA560, 1);
      check("R5 clear in watchdog", int'(bus_rdata[7]), 0);

      // R7/R8 watchdog with rst_enable high
      rst_enable = 1;
      wr(16'hA500, 1);
      wr(16'hA560, 1);
      wait_flag();
      hi = 0;
      while (rst_req && hi < 100) begin hi++; @(negedge clk); end
      check("R7 pulse length", hi, PLEN);
      check("R8 auto clear", int'(bus_rdata[7]), 0);
      rst_enable = 0;
      wr(16'hA500, 1);
      idle(2);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule